// File: doc/BRIEF.md
# Parallel Boot Table Loader

This block runs once after reset and fills program memory from a boot table kept in slow asynchronous external memory. A start pulse makes it read a selection word from a fixed I/O address. That word names the table's base address and the transfer mode. The loader then reads the table word by word. It checks the leading keyword, which also sets the memory width. It passes on two configuration words, saves a two-part entry point, and copies each section to its destination in program memory.

The table can sit in 16-bit memory or in 8-bit memory. In 8-bit memory each program word is built from two successive byte reads. A section whose length is zero ends the load. The loader then presents the saved entry point on its jump output together with a one-cycle done strobe and returns to idle. A bad selection word or a bad keyword raises an error flag, and no program memory write is made.

Reads on both the memory port and the I/O port have a fixed latency: data sampled in the cycle after the read strobe.

Top module: `bt_loader`

## Requirements
- R1: After a synchronous reset, every strobe (io_rd_en, mem_rd_en, prog_we, cfg_wait_vld, cfg_bank_vld, done) is low, busy and boot_err are low, and jump_addr is zero.
- R2: A start pulse in idle causes one read with io_addr = FFFFh. If the low byte of the returned word is not SEL_CODE (default 01h), the loader sets boot_err and makes no memory read. Otherwise the table base is the upper byte of the word followed by eight zero bits.
- R3: A first table read equal to 10AAh selects 16-bit mode. Otherwise a second read is made, and the low bytes of the two reads, first then second, must form 08AAh to select 8-bit mode. Any other result sets boot_err.
- R4: Memory read addresses start at the table base and rise by one with every read in the run.
- R5: In 8-bit mode each table word is the low byte of the first read as bits 15:8 and the low byte of the second read as bits 7:0. Bits 15:8 of the read data are ignored.
- R6: The two words after the keyword appear on cfg_wait and then cfg_bank. Each comes with its own one-cycle valid pulse.
- R7: The next two words form the entry point {upper[6:0], lower[15:0]}, a 23-bit value.
- R8: Each section is a length N, an upper and a lower destination word giving dest = {upper[6:0], lower}, then N words. These N words are written with prog_we to dest, dest+1, … in order, with the carry passing across bit 16.
- R9: A zero length ends the load. In the same cycle, done pulses for one cycle, jump_addr shows the entry point and busy falls.
- R10: boot_err stays high until the next start. While it is high, neither prog_we nor done is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken only when idle) |
| io_rd_en | output | 1 | I/O read strobe for the selection word |
| io_addr | output | 16 | I/O address, fixed at FFFFh |
| io_rdata | input | 16 | I/O read data, valid the cycle after io_rd_en |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_addr | output | 16 | Table memory address |
| mem_rdata | input | 16 | Table read data, valid the cycle after mem_rd_en |
| prog_we | output | 1 | Program memory write strobe |
| prog_addr | output | 23 | Program memory write address |
| prog_wdata | output | 16 | Program memory write data |
| cfg_wait | output | 16 | Wait-state configuration word |
| cfg_wait_vld | output | 1 | One-cycle valid for cfg_wait |
| cfg_bank | output | 16 | Bank-switch configuration word |
| cfg_bank_vld | output | 1 | One-cycle valid for cfg_bank |
| jump_addr | output | 23 | Entry point, updated with done |
| done | output | 1 | One-cycle load-complete strobe |
| busy | output | 1 | Load in progress |
| boot_err | output | 1 | Selection or keyword rejected |

## Verification
The program-memory write for the last code word of a section lands in the same cycle that the loader asks its fetch unit for the next section's length. A stale destination or count update at that edge would corrupt the next section. The bench provokes this with back-to-back sections, one of which is a single word and one of which carries across bit 16 of the destination. The scoreboard judges it by requiring every write address and data in exact order, and by checking each memory read address against a running source counter. The 8-bit run repeats this with garbage in the upper data byte, so mixing up the byte lanes shows up as wrong write data.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL_RD,
    ST_SEL_CHK,
    ST_KEY,
    ST_KEY2,
    ST_CFGW,
    ST_CFGB,
    ST_ENTH,
    ST_ENTL,
    ST_LEN,
    ST_DSTH,
    ST_DSTL,
    ST_CODE
  } bt_state_e;

  localparam logic [15:0] KEY_WIDE   = 16'h10AA;
  localparam logic [15:0] KEY_NARROW = 16'h08AA;

endpackage

// File: rtl/bt_fetch.sv
module bt_fetch #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_load,
  input  logic [AW-1:0] base_addr,
  input  logic          byte_mode,
  input  logic          word_req,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          word_vld,
  output logic [DW-1:0] word_data
);

  localparam int HB = DW / 2;

  logic [AW-1:0] next_addr;
  logic          rd_q;
  logic          phase_q;
  logic [HB-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr <= '0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      rd_q      <= 1'b0;
      phase_q   <= 1'b0;
      hi_q      <= '0;
      word_vld  <= 1'b0;
      word_data <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      word_vld  <= 1'b0;
      rd_q      <= mem_rd_en;
      if (base_load) begin
        next_addr <= base_addr;
      end else if (word_req) begin
        mem_rd_en <= 1'b1;
        mem_addr  <= next_addr;
        next_addr <= next_addr + 1'b1;
        phase_q   <= 1'b0;
      end else if (rd_q) begin
        if (byte_mode && !phase_q) begin
          hi_q      <= mem_rdata[HB-1:0];
          phase_q   <= 1'b1;
          mem_rd_en <= 1'b1;
          mem_addr  <= next_addr;
          next_addr <= next_addr + 1'b1;
        end else begin
          word_vld  <= 1'b1;
          word_data <= byte_mode ? {hi_q, mem_rdata[HB-1:0]} : mem_rdata;
          phase_q   <= 1'b0;
        end
      end
    end
  end

  // Checker state: last issued read address since the base was loaded.
  logic          chk_seen;
  logic [AW-1:0] chk_last;

  always_ff @(posedge clk) begin
    if (rst || base_load) begin
      chk_seen <= 1'b0;
      chk_last <= '0;
    end else if (mem_rd_en) begin
      chk_seen <= 1'b1;
      chk_last <= mem_addr;
    end
  end

  assert_src_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && chk_seen) |-> (mem_addr == AW'(chk_last + 1'b1)));

  assert_byte_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_q && byte_mode && !phase_q) |=> (mem_rd_en && !word_vld));

endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          PAW      = 23,
  parameter int          SELW     = 8,
  parameter logic [SELW-1:0] SEL_CODE = 8'h01
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           io_rd_en,
  input  logic [DW-1:0]  io_rdata,
  output logic           base_load,
  output logic [AW-1:0]  base_addr,
  output logic           byte_mode,
  output logic           word_req,
  input  logic           word_vld,
  input  logic [DW-1:0]  word_data,
  output logic           prog_we,
  output logic [PAW-1:0] prog_addr,
  output logic [DW-1:0]  prog_wdata,
  output logic [DW-1:0]  cfg_wait,
  output logic           cfg_wait_vld,
  output logic [DW-1:0]  cfg_bank,
  output logic           cfg_bank_vld,
  output logic [PAW-1:0] jump_addr,
  output logic           done,
  output logic           busy,
  output logic           boot_err
);

  localparam int HIW = PAW - DW;
  localparam int HB  = DW / 2;
  localparam int UPW = DW - SELW;

  bt_state_e      state_q;
  logic           wait_q;
  logic           byte_q;
  logic [HB-1:0]  key_hi_q;
  logic [HIW-1:0] ent_hi_q;
  logic [DW-1:0]  ent_lo_q;
  logic [HIW-1:0] dst_hi_q;
  logic [PAW-1:0] dst_q;
  logic [DW-1:0]  cnt_q;
  logic           sel_ok;
  logic           needs_word;

  always_comb begin
    sel_ok     = (io_rdata[SELW-1:0] == SEL_CODE);
    base_addr  = {io_rdata[DW-1:SELW], {(AW-UPW){1'b0}}};
    base_load  = (state_q == ST_SEL_CHK) && sel_ok;
    needs_word = (state_q != ST_IDLE) && (state_q != ST_SEL_RD) &&
                 (state_q != ST_SEL_CHK);
    word_req   = needs_word && !wait_q;
    byte_mode  = byte_q && (state_q != ST_KEY) && (state_q != ST_KEY2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      wait_q       <= 1'b0;
      byte_q       <= 1'b0;
      key_hi_q     <= '0;
      ent_hi_q     <= '0;
      ent_lo_q     <= '0;
      dst_hi_q     <= '0;
      dst_q        <= '0;
      cnt_q        <= '0;
      io_rd_en     <= 1'b0;
      prog_we      <= 1'b0;
      prog_addr    <= '0;
      prog_wdata   <= '0;
      cfg_wait     <= '0;
      cfg_wait_vld <= 1'b0;
      cfg_bank     <= '0;
      cfg_bank_vld <= 1'b0;
      jump_addr    <= '0;
      done         <= 1'b0;
      busy         <= 1'b0;
      boot_err     <= 1'b0;
    end else begin
      io_rd_en     <= 1'b0;
      prog_we      <= 1'b0;
      cfg_wait_vld <= 1'b0;
      cfg_bank_vld <= 1'b0;
      done         <= 1'b0;
      if (word_req) wait_q <= 1'b1;
      if (word_vld) wait_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            io_rd_en <= 1'b1;
            boot_err <= 1'b0;
            busy     <= 1'b1;
            byte_q   <= 1'b0;
            state_q  <= ST_SEL_RD;
          end
        end
        ST_SEL_RD: state_q <= ST_SEL_CHK;
        ST_SEL_CHK: begin
          if (sel_ok) begin
            state_q <= ST_KEY;
          end else begin
            boot_err <= 1'b1;
            busy     <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: begin
          if (word_vld) begin
            case (state_q)
              ST_KEY: begin
                if (word_data == KEY_WIDE) begin
                  byte_q  <= 1'b0;
                  state_q <= ST_CFGW;
                end else begin
                  key_hi_q <= word_data[HB-1:0];
                  state_q  <= ST_KEY2;
                end
              end
              ST_KEY2: begin
                if ({key_hi_q, word_data[HB-1:0]} == KEY_NARROW) begin
                  byte_q  <= 1'b1;
                  state_q <= ST_CFGW;
                end else begin
                  boot_err <= 1'b1;
                  busy     <= 1'b0;
                  state_q  <= ST_IDLE;
                end
              end
              ST_CFGW: begin
                cfg_wait     <= word_data;
                cfg_wait_vld <= 1'b1;
                state_q      <= ST_CFGB;
              end
              ST_CFGB: begin
                cfg_bank     <= word_data;
                cfg_bank_vld <= 1'b1;
                state_q      <= ST_ENTH;
              end
              ST_ENTH: begin
                ent_hi_q <= word_data[HIW-1:0];
                state_q  <= ST_ENTL;
              end
              ST_ENTL: begin
                ent_lo_q <= word_data;
                state_q  <= ST_LEN;
              end
              ST_LEN: begin
                if (word_data == '0) begin
                  jump_addr <= {ent_hi_q, ent_lo_q};
                  done      <= 1'b1;
                  busy      <= 1'b0;
                  state_q   <= ST_IDLE;
                end else begin
                  cnt_q   <= word_data;
                  state_q <= ST_DSTH;
                end
              end
              ST_DSTH: begin
                dst_hi_q <= word_data[HIW-1:0];
                state_q  <= ST_DSTL;
              end
              ST_DSTL: begin
                dst_q   <= {dst_hi_q, word_data};
                state_q <= ST_CODE;
              end
              ST_CODE: begin
                prog_we    <= 1'b1;
                prog_addr  <= dst_q;
                prog_wdata <= word_data;
                dst_q      <= dst_q + 1'b1;
                cnt_q      <= cnt_q - 1'b1;
                if (cnt_q == DW'(1)) state_q <= ST_LEN;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    boot_err |-> (!prog_we && !done));

  assert_cfg_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_wait_vld |=> (!cfg_wait_vld && !cfg_bank_vld));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_events_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_we, cfg_wait_vld, cfg_bank_vld, done}));

endmodule

// File: rtl/bt_loader.sv
module bt_loader #(
  parameter int              AW          = 16,
  parameter int              DW          = 16,
  parameter int              PAW         = 23,
  parameter int              SELW        = 8,
  parameter logic [SELW-1:0] SEL_CODE    = 8'h01,
  parameter logic [DW-1:0]   IO_SEL_ADDR = 16'hFFFF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           io_rd_en,
  output logic [DW-1:0]  io_addr,
  input  logic [DW-1:0]  io_rdata,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           prog_we,
  output logic [PAW-1:0] prog_addr,
  output logic [DW-1:0]  prog_wdata,
  output logic [DW-1:0]  cfg_wait,
  output logic           cfg_wait_vld,
  output logic [DW-1:0]  cfg_bank,
  output logic           cfg_bank_vld,
  output logic [PAW-1:0] jump_addr,
  output logic           done,
  output logic           busy,
  output logic           boot_err
);

  logic          base_load;
  logic [AW-1:0] base_addr;
  logic          byte_mode;
  logic          word_req;
  logic          word_vld;
  logic [DW-1:0] word_data;

  assign io_addr = IO_SEL_ADDR;

  bt_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .base_load (base_load),
    .base_addr (base_addr),
    .byte_mode (byte_mode),
    .word_req  (word_req),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .word_vld  (word_vld),
    .word_data (word_data)
  );

  bt_ctrl #(
    .AW(AW), .DW(DW), .PAW(PAW), .SELW(SELW), .SEL_CODE(SEL_CODE)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .io_rd_en     (io_rd_en),
    .io_rdata     (io_rdata),
    .base_load    (base_load),
    .base_addr    (base_addr),
    .byte_mode    (byte_mode),
    .word_req     (word_req),
    .word_vld     (word_vld),
    .word_data    (word_data),
    .prog_we      (prog_we),
    .prog_addr    (prog_addr),
    .prog_wdata   (prog_wdata),
    .cfg_wait     (cfg_wait),
    .cfg_wait_vld (cfg_wait_vld),
    .cfg_bank     (cfg_bank),
    .cfg_bank_vld (cfg_bank_vld),
    .jump_addr    (jump_addr),
    .done         (done),
    .busy         (busy),
    .boot_err     (boot_err)
  );

endmodule

// File: tb/bt_loader_bench.sv
module bt_loader_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        io_rd_en;
  logic [15:0] io_addr;
  logic [15:0] io_rdata = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        prog_we;
  logic [22:0] prog_addr;
  logic [15:0] prog_wdata;
  logic [15:0] cfg_wait;
  logic        cfg_wait_vld;
  logic [15:0] cfg_bank;
  logic        cfg_bank_vld;
  logic [22:0] jump_addr;
  logic        done;
  logic        busy;
  logic        boot_err;

  always #10 clk = ~clk;

  bt_loader u_bt_loader (
    .clk(clk), .rst(rst), .start(start),
    .io_rd_en(io_rd_en), .io_addr(io_addr), .io_rdata(io_rdata),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .cfg_wait(cfg_wait), .cfg_wait_vld(cfg_wait_vld),
    .cfg_bank(cfg_bank), .cfg_bank_vld(cfg_bank_vld),
    .jump_addr(jump_addr), .done(done), .busy(busy), .boot_err(boot_err)
  );

  // Memory and I/O models: one-cycle read latency.
  logic [15:0] mem [0:2047];
  logic [15:0] sel_word = '0;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[10:0]];
    if (io_rd_en)  io_rdata  <= sel_word;
  end

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 cfg wait, 2 cfg bank, 3 done
    logic [22:0] addr;
    logic [15:0] data;
  } ev_t;

  ev_t         scb[$];
  int          checks = 0;
  int          errors = 0;
  int          wp;
  logic        bmode;
  logic [15:0] exp_src;
  int          nreads;
  string       wr_req = "R8";
  logic [22:0] exp_jump;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [22:0] a, input logic [15:0] d);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d;
    scb.push_back(e);
  endtask

  // Store one table word; in 8-bit mode as two bytes with junk upper lanes (R5).
  task automatic pw(input logic [15:0] v);
    if (bmode) begin
      mem[wp[10:0]]     = {8'hC3, v[15:8]};
      mem[wp[10:0] + 1] = {8'h5A, v[7:0]};
      wp += 2;
    end else begin
      mem[wp[10:0]] = v;
      wp += 1;
    end
  endtask

  task automatic header(input logic [15:0] base, input logic m,
                        input logic [15:0] cw, input logic [15:0] cb,
                        input logic [15:0] eh, input logic [15:0] el);
    wp = int'(base[10:0]);
    bmode = m;
    pw(m ? 16'h08AA : 16'h10AA);
    pw(cw); push(2'd1, '0, cw);
    pw(cb); push(2'd2, '0, cb);
    pw(eh); pw(el);
    exp_jump = {eh[6:0], el};
  endtask

  task automatic section(input logic [15:0] len, input logic [15:0] dh,
                         input logic [15:0] dl, input logic [15:0] seed);
    logic [22:0] d;
    pw(len); pw(dh); pw(dl);
    for (int i = 0; i < int'(len); i++) begin
      d = {dh[6:0], dl} + 23'(i);
      pw(seed + 16'(i) * 16'h0111);
      push(2'd0, d, seed + 16'(i) * 16'h0111);
    end
  endtask

  task automatic finish_table();
    pw(16'h0000);
    push(2'd3, exp_jump, '0);
  endtask

  task automatic run(input logic [15:0] sel, input logic exp_err,
                     input int exp_reads, input string req);
    sel_word = sel;
    exp_src  = {sel[15:8], 8'h00};
    nreads   = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(boot_err == exp_err, req, "boot_err after run", 32'(boot_err), 32'(exp_err));
    chk(scb.size() == 0, "R9", "expected events left over", scb.size(), 0);
    if (exp_reads >= 0)
      chk(nreads == exp_reads, req, "table read count", nreads, exp_reads);
    scb.delete();
  endtask

  // Monitor: source address stream and scoreboard of output events.
  always @(negedge clk) begin
    ev_t e;
    if (!rst) begin
      if (mem_rd_en) begin
        chk(mem_addr == exp_src, "R4", "read address", 32'(mem_addr), 32'(exp_src));
        exp_src = exp_src + 1'b1;
        nreads++;
      end
      if (io_rd_en)
        chk(io_addr == 16'hFFFF, "R2", "selection I/O address", 32'(io_addr), 32'hFFFF);
      if (prog_we || cfg_wait_vld || cfg_bank_vld || done) begin
        if (scb.size() == 0) begin
          chk(1'b0, "R10", "unexpected output event",
              {prog_we, cfg_wait_vld, cfg_bank_vld, done}, 0);
        end else begin
          e = scb.pop_front();
          case (e.kind)
            2'd0: chk(prog_we && prog_addr == e.addr && prog_wdata == e.data, wr_req,
                      "program write {addr,data}", {prog_addr[15:0], prog_wdata},
                      {e.addr[15:0], e.data});
            2'd1: chk(cfg_wait_vld && cfg_wait == e.data, "R6", "cfg_wait",
                      32'(cfg_wait), 32'(e.data));
            2'd2: chk(cfg_bank_vld && cfg_bank == e.data, "R6", "cfg_bank",
                      32'(cfg_bank), 32'(e.data));
            default: begin
              chk(done && !busy, "R9", "done strobe with busy low",
                  {done, busy}, 32'h2);
              chk(jump_addr == e.addr, "R7", "jump_addr", 32'(jump_addr), 32'(e.addr));
            end
          endcase
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !boot_err && !done && !prog_we, "R1", "status after reset",
        {busy, boot_err, done, prog_we}, 0);
    chk(!io_rd_en && !mem_rd_en && !cfg_wait_vld && !cfg_bank_vld, "R1",
        "strobes after reset", {io_rd_en, mem_rd_en, cfg_wait_vld, cfg_bank_vld}, 0);
    chk(jump_addr == '0, "R1", "jump_addr after reset", 32'(jump_addr), 0);

    // 16-bit table: carry across bit 16, then a single-word section (R3, R8)
    wr_req = "R8";
    header(16'h0400, 1'b0, 16'h1234, 16'hBEEF, 16'hFFAB, 16'h1000);
    section(16'd3, 16'h0001, 16'hFFFE, 16'hA000);
    section(16'd1, 16'h0000, 16'h0500, 16'h7777);
    finish_table();
    run(16'h0401, 1'b0, 1 + 4 + 3 + 3 + 3 + 1 + 1, "R3");

    // 8-bit table with junk upper lanes (R5)
    wr_req = "R5";
    header(16'h0800, 1'b1, 16'h0900, 16'h00F1, 16'h0041, 16'h2468);
    section(16'd2, 16'h0002, 16'h0100, 16'h1357);
    section(16'd4, 16'h0000, 16'h0040, 16'hC0DE);
    finish_table();
    run(16'h0801, 1'b0, 2 * (1 + 4 + 3 + 2 + 3 + 4 + 1), "R5");

    // Bad keyword in 16-bit memory: two reads, error, no writes (R3, R10)
    mem[11'h400] = 16'h1234;
    mem[11'h401] = 16'h0000;
    run(16'h0401, 1'b1, 2, "R3");

    // 8-bit keyword with a wrong second byte (R3)
    mem[11'h400] = 16'h0008;
    mem[11'h401] = 16'h00AB;
    run(16'h0401, 1'b1, 2, "R3");

    // Wrong selection code: no table reads (R2)
    run(16'h0402, 1'b1, 0, "R2");

    // Zero length right after the entry point; error cleared by new start (R9, R10)
    wr_req = "R8";
    header(16'h0400, 1'b0, 16'h0001, 16'h0002, 16'h007F, 16'hFFFF);
    finish_table();
    run(16'h0401, 1'b0, 6, "R10");
    chk(jump_addr == 23'h7FFFFF, "R7", "held jump_addr", 32'(jump_addr), 32'h7FFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule